// File: doc/BRIEF.md
# Two-Wire Serial Memory Target Engine

This block is the bus-facing half of a 4096-byte two-wire (I2C) serial memory. It oversamples the SCL and SDA lines on a fast system clock, cleans them with a synchroniser and a short stability filter, and finds START and STOP conditions and clock edges. A protocol engine then decodes the command byte and loads a 12-bit address counter from two address bytes. It serves byte writes, page writes, current-address reads, random reads and sequential reads. SDA is driven as an open-drain pull-down through `sda_oe`.

The storage array and its programming timer sit outside the block. Reads use an asynchronous read port: the engine presents `mem_raddr` and takes `mem_rdata` in the same cycle. Writes go to an external staging buffer, one `wb_we` pulse per received data byte. A one-cycle `commit` pulse at STOP tells the programming logic to burn the staged bytes. While that logic holds `prog_busy`, the engine refuses its command byte, so a master can poll for completion.

Top module: `sermem_target`

## Requirements
- R1: After reset `sda_oe`, `wb_we` and `commit` are low and `mem_raddr` is 0.
- R2: A command byte whose bits 7..4 are 1010 and whose bits 3..1 equal `cs_strap` (bit 3 against `cs_strap[2]`) is acknowledged; bit 0 selects read (1) or write (0). Any other command byte is not acknowledged, and the rest of the transfer up to the next START causes no acknowledge and no `wb_we`.
- R3: While `prog_busy` is high, a matching command byte is not acknowledged, for both read and write.
- R4: After a write command, the first address byte supplies counter bits 11..8 from its low nibble and the second byte supplies bits 7..0. Each byte is acknowledged, and `mem_raddr` shows the loaded address once the second byte is acknowledged.
- R5: Each data byte after the two address bytes is acknowledged and produces one `wb_we` pulse carrying the counter and the byte. The counter then advances in bits 4..0 only, so it wraps within a 32-byte page.
- R6: A STOP after at least one data byte gives exactly one one-cycle `commit` pulse. A STOP with no data byte since the last START gives none.
- R7: A read command returns the byte at the current counter, MSB first, and leaves the counter one higher.
- R8: A write command with two address bytes, a repeated START and a read command returns the byte at the loaded address.
- R9: A read continues while the master acknowledges, and the counter wraps from 4095 to 0. A master no-acknowledge ends the read and leaves SDA released.
- R10: A START at any bit position aborts the transfer in progress and makes the engine receive a new command byte.
- R11: The engine changes its SDA drive only in the cycle after an SCL falling edge, START or STOP, so its data stays stable while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| cs_strap | input | 3 | Device select straps compared with command bits 3..1 |
| prog_busy | input | 1 | Programming cycle in progress |
| mem_raddr | output | 12 | Address counter, used as the array read address |
| mem_rdata | input | 8 | Array byte at `mem_raddr`, same cycle |
| wb_we | output | 1 | One-cycle write strobe into the staging buffer |
| wb_addr | output | 12 | Address of the staged byte |
| wb_data | output | 8 | Staged byte |
| commit | output | 1 | One-cycle pulse: start programming staged bytes |

## Verification
A corrupted bit counter or shift register shows up within one byte time as an acknowledge in the wrong clock slot or as a wrong bit in the data read back. A wrong address counter shows up on `mem_raddr` right after the second address byte, and in the next byte read or the next `wb_addr`. A wrong state after a START, a STOP or a busy refusal shows up as an acknowledge that is missing or should not be there on the very next command byte. A lost or repeated `commit` shows up as a missing or extra pulse in the cycle after the STOP is filtered.

// File: rtl/sermem_pkg.sv
package sermem_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_AHI,
    ST_ALO,
    ST_WDATA,
    ST_RDATA
  } eng_state_t;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
  localparam int         CS_W     = 3;
endpackage

// File: rtl/sermem_deglitch.sv
module sermem_deglitch #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic          s1, s2;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1   <= 1'b1;
      s2   <= 1'b1;
      dout <= 1'b1;
      cnt  <= '0;
    end else begin
      s1 <= din;
      s2 <= s1;
      if (s2 != dout) begin
        if (cnt == CW'(FILT_LEN - 1)) begin
          dout <= s2;
          cnt  <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/sermem_bus_events.sv
module sermem_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise = scl_f & ~scl_q;
  assign scl_fall = ~scl_f & scl_q;
  assign start_ev = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_ev  = scl_f & scl_q & ~sda_q & sda_f;
endmodule

// File: rtl/sermem_engine.sv
module sermem_engine
  import sermem_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_f,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic [CS_W-1:0]   cs_strap,
  input  logic              prog_busy,
  input  logic [7:0]        mem_rdata,
  output logic              sda_oe,
  output logic [ADDR_W-1:0] mem_raddr,
  output logic              wb_we,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [7:0]        wb_data,
  output logic              commit
);
  localparam int BCNT_W = 4;

  function automatic logic f_cmd_hit(input logic [7:0] b, input logic [CS_W-1:0] strap);
    return (b[7:4] == DEV_TYPE) && (b[CS_W:1] == strap);
  endfunction

  function automatic logic [ADDR_W-1:0] f_page_step(input logic [ADDR_W-1:0] a);
    logic [PAGE_W-1:0] low;
    low = a[PAGE_W-1:0] + PAGE_W'(1);
    return {a[ADDR_W-1:PAGE_W], low};
  endfunction

  eng_state_t        st;
  logic [BCNT_W-1:0] bcnt;
  logic [7:0]        shreg, txsh;
  logic [ADDR_W-1:0] addr;
  logic              mack, wrote;
  logic [2:0]        tx_idx;

  // named internal events for the checks below
  logic byte_end, ack_end, cmd_done;
  assign byte_end = scl_fall && (bcnt == BCNT_W'(8)) && (st != ST_IDLE);
  assign ack_end  = scl_fall && (bcnt == BCNT_W'(9)) && (st != ST_IDLE);
  assign cmd_done = byte_end && (st == ST_CMD);
  assign tx_idx   = 3'(BCNT_W'(7) - bcnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      bcnt    <= '0;
      shreg   <= '0;
      txsh    <= '0;
      addr    <= '0;
      mack    <= 1'b0;
      wrote   <= 1'b0;
      sda_oe  <= 1'b0;
      wb_we   <= 1'b0;
      wb_addr <= '0;
      wb_data <= '0;
      commit  <= 1'b0;
    end else begin
      wb_we  <= 1'b0;
      commit <= 1'b0;
      if (start_ev) begin
        st     <= ST_CMD;
        bcnt   <= '0;
        sda_oe <= 1'b0;
        wrote  <= 1'b0;
      end else if (stop_ev) begin
        commit <= wrote;
        wrote  <= 1'b0;
        st     <= ST_IDLE;
        bcnt   <= '0;
        sda_oe <= 1'b0;
      end else if (st != ST_IDLE) begin
        if (scl_rise) begin
          if (bcnt < BCNT_W'(8)) shreg <= {shreg[6:0], sda_f};
          else                   mack  <= ~sda_f;
          if (bcnt != BCNT_W'(9)) bcnt <= bcnt + 1'b1;
        end else if (byte_end) begin
          sda_oe <= 1'b0;
          case (st)
            ST_CMD: begin
              if (f_cmd_hit(shreg, cs_strap) && !prog_busy) begin
                sda_oe <= 1'b1;
                mack   <= 1'b1;
                st     <= shreg[0] ? ST_RDATA : ST_AHI;
              end else begin
                st <= ST_IDLE;
              end
            end
            ST_AHI: begin
              sda_oe             <= 1'b1;
              addr[ADDR_W-1:8]   <= shreg[ADDR_W-9:0];
              st                 <= ST_ALO;
            end
            ST_ALO: begin
              sda_oe     <= 1'b1;
              addr[7:0]  <= shreg;
              st         <= ST_WDATA;
            end
            ST_WDATA: begin
              sda_oe  <= 1'b1;
              wb_we   <= 1'b1;
              wb_addr <= addr;
              wb_data <= shreg;
              addr    <= f_page_step(addr);
              wrote   <= 1'b1;
            end
            default: ;
          endcase
        end else if (ack_end) begin
          bcnt   <= '0;
          sda_oe <= 1'b0;
          if (st == ST_RDATA) begin
            if (mack) begin
              txsh   <= mem_rdata;
              sda_oe <= ~mem_rdata[7];
              addr   <= addr + 1'b1;
            end else begin
              st <= ST_IDLE;
            end
          end
        end else if (scl_fall && st == ST_RDATA && bcnt != '0) begin
          sda_oe <= ~txsh[tx_idx];
        end
      end
    end
  end

  assign mem_raddr = addr;

  // R3: a refused command byte never turns into an acknowledge
  p_busy_nak_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_done && prog_busy) |=> !sda_oe);

  // R5: staged bytes of one burst share the page of the counter
  p_wb_page_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wb_we |-> (addr[ADDR_W-1:PAGE_W] == wb_addr[ADDR_W-1:PAGE_W]));

  // R6: commit is a single-cycle pulse
  p_commit_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);

  // R9: no drive once the engine has dropped out of a transfer
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_oe);

  // R11: drive changes only after a falling SCL edge or a bus condition
  p_drive_after_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(scl_fall) && !$past(start_ev) && !$past(stop_ev)) |-> $stable(sda_oe));
endmodule

// File: rtl/sermem_target.sv
module sermem_target #(
  parameter int ADDR_W   = 12,
  parameter int PAGE_W   = 5,
  parameter int FILT_LEN = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [2:0]        cs_strap,
  input  logic              prog_busy,
  output logic [ADDR_W-1:0] mem_raddr,
  input  logic [7:0]        mem_rdata,
  output logic              wb_we,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [7:0]        wb_data,
  output logic              commit
);
  localparam int N_LINES = 2;

  logic [N_LINES-1:0] line_raw, line_flt;
  logic scl_rise, scl_fall, start_ev, stop_ev;

  assign line_raw = {sda_i, scl_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    sermem_deglitch #(.FILT_LEN(FILT_LEN)) u_dg (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (line_raw[g]),
      .dout (line_flt[g])
    );
  end

  sermem_bus_events u_ev (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_f   (line_flt[0]),
    .sda_f   (line_flt[1]),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall),
    .start_ev(start_ev),
    .stop_ev (stop_ev)
  );

  sermem_engine #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .sda_f    (line_flt[1]),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .cs_strap (cs_strap),
    .prog_busy(prog_busy),
    .mem_rdata(mem_rdata),
    .sda_oe   (sda_oe),
    .mem_raddr(mem_raddr),
    .wb_we    (wb_we),
    .wb_addr  (wb_addr),
    .wb_data  (wb_data),
    .commit   (commit)
  );
endmodule

// File: tb/test_sermem_target.sv
module test_sermem_target;
  localparam int Q      = 20;
  localparam int BUSY   = 3000;
  localparam logic [7:0] CMD_W = 8'hAA;  // 1010 101 0
  localparam logic [7:0] CMD_R = 8'hAB;  // 1010 101 1
  localparam logic [7:0] CMD_X = 8'hA4;  // straps 010: no match

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, wb_we, commit, prog_busy;
  logic [11:0] mem_raddr, wb_addr;
  logic [7:0]  mem_rdata, wb_data;
  logic [2:0]  cs_strap = 3'b101;
  wire         sda_bus = sda_m & ~sda_oe;

  logic [7:0]  mem [4096];
  logic [11:0] st_addr [64];
  logic [7:0]  st_data [64];
  int n_st = 0, n_we = 0, n_commit = 0, busy_cnt = 0;
  int n_chk = 0, n_fail = 0, unstable = 0;

  function automatic logic [7:0] pat(input int a);
    return 8'(a * 7 + 3);
  endfunction

  assign mem_rdata = mem[mem_raddr];
  assign prog_busy = (busy_cnt != 0);

  sermem_target i_sermem_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .cs_strap(cs_strap), .prog_busy(prog_busy), .mem_raddr(mem_raddr),
    .mem_rdata(mem_rdata), .wb_we(wb_we), .wb_addr(wb_addr), .wb_data(wb_data),
    .commit(commit)
  );

  // array and programming-timer model
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4096; i++) mem[i] <= pat(i);
    end else begin
      if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
      if (wb_we) begin
        st_addr[n_st] <= wb_addr;
        st_data[n_st] <= wb_data;
        n_st <= n_st + 1;
        n_we <= n_we + 1;
      end
      if (commit) begin
        for (int i = 0; i < n_st; i++) mem[st_addr[i]] <= st_data[i];
        n_st     <= 0;
        n_commit <= n_commit + 1;
        busy_cnt <= BUSY;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq;
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wq; scl_m = 1'b1; wq; sda_m = 1'b0; wq; scl_m = 1'b0; wq;
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wq; scl_m = 1'b1; wq; sda_m = 1'b1; wq;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq; scl_m = 1'b1; wq; wq; scl_m = 1'b0; wq;
    end
    sda_m = 1'b1; wq; scl_m = 1'b1; wq; ack = ~sda_bus; wq; scl_m = 1'b0; wq;
  endtask

  task automatic send_bits(input int n, input logic [7:0] b);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wq; scl_m = 1'b1; wq; wq; scl_m = 1'b0; wq;
    end
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    logic first;
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq; scl_m = 1'b1; wq; b[i] = sda_bus; first = sda_bus;
      repeat (Q - 2) @(posedge clk); #1;
      if (sda_bus != first) unstable++;
      @(posedge clk); #1;
      scl_m = 1'b0;
    end
    wq; sda_m = ~mack; wq; scl_m = 1'b1; wq; wq; scl_m = 1'b0; wq; sda_m = 1'b1;
  endtask

  task automatic set_addr(input logic [11:0] a, input string tag);
    logic ack;
    bus_start;
    send_byte(CMD_W, ack);       chk(ack, {tag, " cmd ack"}, ack, 1);
    send_byte({4'h0, a[11:8]}, ack); chk(ack, "R4 high address ack", ack, 1);
    send_byte(a[7:0], ack);      chk(ack, "R4 low address ack", ack, 1);
  endtask

  task automatic wait_ready;
    logic ack;
    for (int t = 0; t < 20; t++) begin
      bus_start; send_byte(CMD_W, ack); bus_stop;
      if (ack) break;
    end
    chk(ack, "R3 ack returns after programming", ack, 1);
  endtask

  task automatic t_reset;
    chk(sda_oe == 0 && wb_we == 0 && commit == 0, "R1 outputs idle", {sda_oe, wb_we, commit}, 0);
    chk(mem_raddr == 0, "R1 counter", mem_raddr, 0);
  endtask

  task automatic t_mismatch;
    logic ack; int we0;
    we0 = n_we;
    bus_start;
    send_byte(CMD_X, ack); chk(!ack, "R2 foreign straps not acked", ack, 0);
    send_byte(8'h00, ack); chk(!ack, "R2 ignored after mismatch", ack, 0);
    send_byte(8'h55, ack);
    bus_stop;
    chk(n_we == we0, "R2 no staging after mismatch", n_we, we0);
  endtask

  task automatic t_byte_write;
    logic ack; int c0;
    c0 = n_commit;
    set_addr(12'h123, "R2 write");
    chk(mem_raddr == 12'h123, "R4 counter loaded", mem_raddr, 12'h123);
    send_byte(8'hA5, ack); chk(ack, "R5 data ack", ack, 1);
    chk(wb_addr == 12'h123 && wb_data == 8'hA5, "R5 staged byte", {wb_addr, wb_data}, {12'h123, 8'hA5});
    bus_stop;
    repeat (4) @(posedge clk); #1;
    chk(n_commit == c0 + 1, "R6 one commit", n_commit, c0 + 1);
  endtask

  task automatic t_busy;
    logic ack; int c0;
    c0 = n_commit;
    bus_start; send_byte(CMD_W, ack); bus_stop;
    chk(!ack, "R3 write cmd refused while busy", ack, 0);
    bus_start; send_byte(CMD_R, ack); bus_stop;
    chk(!ack, "R3 read cmd refused while busy", ack, 0);
    chk(n_commit == c0, "R6 no commit without data", n_commit, c0);
    wait_ready;
  endtask

  task automatic t_page_wrap;
    logic ack; logic [7:0] b; int s0;
    logic [11:0] ea [4];
    ea[0] = 12'h05E; ea[1] = 12'h05F; ea[2] = 12'h040; ea[3] = 12'h041;
    set_addr(12'h05E, "R2 write");
    for (int i = 0; i < 4; i++) begin
      send_byte(8'(8'h11 * (i + 1)), ack);
      chk(ack && wb_addr == ea[i], "R5 page wrap address", wb_addr, ea[i]);
    end
    bus_stop;
    wait_ready;
    set_addr(12'h040, "R2 write");
    bus_start; send_byte(CMD_R, ack); chk(ack, "R8 read cmd ack", ack, 1);
    recv_byte(1'b0, b); bus_stop;
    s0 = 8'h33;
    chk(b == 8'(s0), "R8 read after wrapped write", b, s0);
  endtask

  task automatic t_random_read;
    logic ack; logic [7:0] b;
    set_addr(12'h123, "R8 write");
    bus_start; send_byte(CMD_R, ack); chk(ack, "R8 read cmd ack", ack, 1);
    recv_byte(1'b0, b); bus_stop;
    chk(b == 8'hA5, "R8 random read data", b, 8'hA5);
    chk(mem_raddr == 12'h124, "R7 counter advanced", mem_raddr, 12'h124);
  endtask

  task automatic t_current_read;
    logic ack; logic [7:0] b;
    bus_start; send_byte(CMD_R, ack); chk(ack, "R7 read cmd ack", ack, 1);
    recv_byte(1'b0, b); bus_stop;
    chk(b == pat(12'h124), "R7 current address data", b, pat(12'h124));
  endtask

  task automatic t_seq_wrap;
    logic ack; logic [7:0] b;
    int ea [3];
    ea[0] = 12'hFFE; ea[1] = 12'hFFF; ea[2] = 0;
    unstable = 0;
    set_addr(12'hFFE, "R9 write");
    bus_start; send_byte(CMD_R, ack); chk(ack, "R9 read cmd ack", ack, 1);
    for (int i = 0; i < 3; i++) begin
      recv_byte(i != 2, b);
      chk(b == pat(ea[i]), "R9 sequential data", b, pat(ea[i]));
    end
    chk(sda_oe == 0, "R9 released after nack", sda_oe, 0);
    bus_stop;
    chk(unstable == 0, "R11 data stable while SCL high", unstable, 0);
    chk(mem_raddr == 12'h001, "R9 counter wrapped", mem_raddr, 1);
  endtask

  task automatic t_abort;
    logic ack; logic [7:0] b;
    bus_start; send_byte(CMD_W, ack);
    send_bits(3, 8'hA0);
    bus_start;
    send_byte(CMD_R, ack); chk(ack, "R10 command after abort", ack, 1);
    recv_byte(1'b0, b); bus_stop;
    chk(b == pat(1), "R10 counter untouched by aborted byte", b, pat(1));
  endtask

  initial begin
    repeat (20) @(posedge clk); #1;
    t_reset;
    rst_n = 1'b1;
    repeat (20) @(posedge clk); #1;
    t_reset;
    t_mismatch;
    t_byte_write;
    t_busy;
    t_random_read;
    t_current_read;
    t_page_wrap;
    t_seq_wrap;
    t_abort;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule